// File: doc/BRIEF.md
# Section-Capable Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. A first-level table of 4096 word-sized entries (16 KB) covers the whole address space, one entry per megabyte. Each entry's two low bits give its kind. A section entry finishes the translation at once with a 1 MB mapping. A table entry points to a second-level table of 256 entries, which splits that megabyte into 4 KB pages. Every pointer held in the tables is physical. The virtual address is never stored. It is implied by where the entry sits in each table.

A client raises a request with the virtual address and the first-level table base while the walker is idle. The walker issues one or two word reads on a simple read port. Each read completes when memory raises a response strobe, after any delay. The walker then reports a one-cycle completion pulse with the physical address, the entry's twelve low flag bits and the level that ended the walk, or a fault.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `busy`, `done`, `mem_rd_en`, `fault` and `level` are 0, and `paddr`, `flags` and `mem_rd_addr` are 0.
- R2: A request sampled while idle causes a one-cycle `mem_rd_en` at the next edge. Its `mem_rd_addr` is `{ttb[31:14], vaddr[31:20], 2'b00}`, so the low 14 base bits are ignored. `busy` rises at the same edge.
- R3: A first-level entry whose bits [1:0] are 2'b10 (section) ends the walk at the edge that samples the response. The outputs are `done`=1, `fault`=0, `level`=0, `paddr = {entry[31:20], vaddr[19:0]}` and `flags = entry[11:0]`, and no further read is made.
- R4: A first-level entry whose bits [1:0] are 2'b01 (table pointer) causes a second read at the edge that samples the response. Its address is `{entry[31:10], vaddr[19:12], 2'b00}`.
- R5: A second-level entry with bit 1 set ends the walk with `done`=1, `fault`=0, `level`=1, `paddr = {entry[31:12], vaddr[11:0]}` and `flags = entry[11:0]`.
- R6: A first-level entry whose bits [1:0] are 2'b00 or 2'b11 ends the walk with `done`=1, `fault`=1, `level`=0, `paddr`=0 and `flags`=0, and no further read is made.
- R7: A second-level entry with bit 1 clear ends the walk with `done`=1, `fault`=1, `level`=1, `paddr`=0 and `flags`=0.
- R8: A request raised while `busy` is high is ignored, and so is a response strobe while idle. Neither changes any output.
- R9: `done` lasts one cycle and `busy` falls at the same edge. `paddr`, `flags`, `fault` and `level` hold their values until the next completion.
- R10: The walker waits any number of cycles for a response, with `busy` held high, and completes only on a response strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| ttb | input | 32 | First-level table base, 16 KB aligned (low bits ignored) |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 32 | Physical word address of the read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completed walk faulted |
| level | output | 1 | Level that ended the walk: 0 first, 1 second |
| paddr | output | 32 | Translated physical address |
| flags | output | 12 | Low flag bits of the final entry |

## Verification
The first read strobe and its address are due at the edge after the request is sampled. A second-level read is due at the edge that samples the first response. A result is due at the edge that samples the final response, so a walk spans the request edge plus each response edge, whatever the memory delay. The bench holds a behavioural model that is advanced at each rising edge from the same inputs. It compares every output against that model at each falling edge, so a result one cycle early or late fails. Memory delays of zero and several cycles, a request made during a walk and a response strobe while idle are all exercised. Each completed walk is also checked against values worked out by hand.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} walk_st_t;
  typedef enum logic [1:0] {
    K_FAULT   = 2'b00,
    K_TABLE   = 2'b01,
    K_SECTION = 2'b10,
    K_RSVD    = 2'b11
  } l1_kind_t;
  typedef enum logic [1:0] {ACT_FAULT, ACT_DONE, ACT_NEXT} step_t;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int L2_IDX_W = 8,
  parameter int PG_OFF_W = 12
) (
  input  logic [VA_W-1:0] req_va,
  input  logic [PA_W-1:0] req_base,
  input  logic [VA_W-1:0] walk_va,
  input  logic [PA_W-1:0] entry,
  output logic [PA_W-1:0] l1_addr,
  output logic [PA_W-1:0] l2_addr,
  output logic [PA_W-1:0] sec_pa,
  output logic [PA_W-1:0] page_pa
);
  localparam int SEC_OFF_W = L2_IDX_W + PG_OFF_W;
  localparam int L1_IDX_W  = VA_W - SEC_OFF_W;
  localparam int L1_ALIGN  = L1_IDX_W + 2;
  localparam int L2_ALIGN  = L2_IDX_W + 2;

  // first-level index picks a word inside a table aligned to its own size
  assign l1_addr = {req_base[PA_W-1:L1_ALIGN], req_va[VA_W-1:SEC_OFF_W], 2'b00};
  assign l2_addr = {entry[PA_W-1:L2_ALIGN], walk_va[SEC_OFF_W-1:PG_OFF_W], 2'b00};
  assign sec_pa  = {entry[PA_W-1:SEC_OFF_W], walk_va[SEC_OFF_W-1:0]};
  assign page_pa = {entry[PA_W-1:PG_OFF_W], walk_va[PG_OFF_W-1:0]};

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_base[L1_ALIGN-1:0], req_va[SEC_OFF_W-1:0],
                              walk_va[VA_W-1:SEC_OFF_W], entry[L2_ALIGN-1:0]};
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int ENTRY_W   = 32,
  parameter int VALID_BIT = 1
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic               is_l2,
  output step_t              step
);
  always_comb begin
    step = ACT_FAULT;
    if (is_l2) begin
      step = entry[VALID_BIT] ? ACT_DONE : ACT_FAULT;
    end else begin
      case (l1_kind_t'(entry[1:0]))
        K_SECTION: step = ACT_DONE;
        K_TABLE:   step = ACT_NEXT;
        default:   step = ACT_FAULT;
      endcase
    end
  end

  logic unused_entry_bits;
  assign unused_entry_bits = ^entry;
endmodule

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walker_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int FLAG_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              rsp_valid,
  input  logic [PA_W-1:0]   rsp_data,
  input  step_t             step,
  input  logic [PA_W-1:0]   l1_addr,
  input  logic [PA_W-1:0]   l2_addr,
  input  logic [PA_W-1:0]   sec_pa,
  input  logic [PA_W-1:0]   page_pa,
  output logic [VA_W-1:0]   va_q,
  output logic              in_l2,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_rd_addr,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              level,
  output logic [PA_W-1:0]   paddr,
  output logic [FLAG_W-1:0] flags
);
  walk_st_t st;

  assign in_l2 = (st == ST_L2);
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      va_q        <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      fault       <= 1'b0;
      level       <= 1'b0;
      paddr       <= '0;
      flags       <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q        <= req_vaddr;
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= l1_addr;
            st          <= ST_L1;
          end
        end
        ST_L1, ST_L2: begin
          if (rsp_valid) begin
            case (step)
              ACT_NEXT: begin
                mem_rd_en   <= 1'b1;
                mem_rd_addr <= l2_addr;
                st          <= ST_L2;
              end
              ACT_DONE: begin
                done  <= 1'b1;
                fault <= 1'b0;
                level <= in_l2;
                paddr <= in_l2 ? page_pa : sec_pa;
                flags <= rsp_data[FLAG_W-1:0];
                st    <= ST_IDLE;
              end
              default: begin
                done  <= 1'b1;
                fault <= 1'b1;
                level <= in_l2;
                paddr <= '0;
                flags <= '0;
                st    <= ST_IDLE;
              end
            endcase
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic unused_rsp_hi;
  assign unused_rsp_hi = ^rsp_data[PA_W-1:FLAG_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int PA_W         = 32,
  parameter int L2_IDX_W     = 8,
  parameter int PG_OFF_W     = 12,
  parameter int L2_VALID_BIT = 1,
  localparam int FLAG_W      = PG_OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   ttb,
  output logic              mem_rd_en,
  output logic [PA_W-1:0]   mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [PA_W-1:0]   mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic              level,
  output logic [PA_W-1:0]   paddr,
  output logic [FLAG_W-1:0] flags
);
  logic [VA_W-1:0] va_q;
  logic            in_l2;
  step_t           step;
  logic [PA_W-1:0] l1_addr, l2_addr, sec_pa, page_pa;

  pt_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .L2_IDX_W(L2_IDX_W), .PG_OFF_W(PG_OFF_W)
  ) u_addr (
    .req_va(req_vaddr), .req_base(ttb), .walk_va(va_q), .entry(mem_rsp_data),
    .l1_addr(l1_addr), .l2_addr(l2_addr), .sec_pa(sec_pa), .page_pa(page_pa)
  );

  pt_entry_decode #(
    .ENTRY_W(PA_W), .VALID_BIT(L2_VALID_BIT)
  ) u_dec (
    .entry(mem_rsp_data), .is_l2(in_l2), .step(step)
  );

  pt_walk_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .FLAG_W(FLAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data), .step(step),
    .l1_addr(l1_addr), .l2_addr(l2_addr), .sec_pa(sec_pa), .page_pa(page_pa),
    .va_q(va_q), .in_l2(in_l2), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .busy(busy), .done(done), .fault(fault), .level(level),
    .paddr(paddr), .flags(flags)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_rd_en,
  input logic            mem_rsp_valid,
  input logic            busy,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr
);
  p_rd_in_walk_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  p_accept_reads_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_rd_en);

  p_fault_zero_pa_r6: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_after_rsp_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid));

  p_wait_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_rsp_valid) |=> busy);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_rsp_valid(mem_rsp_valid),
  .busy(busy), .done(done), .fault(fault), .paddr(paddr)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] ttb = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, done, fault, level;
  logic [31:0] paddr;
  logic [11:0] flags;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_tag = "R1";

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr), .ttb(ttb),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .done(done), .fault(fault), .level(level),
    .paddr(paddr), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory image and responder
  logic [31:0] mem_img [logic [31:0]];
  int          rsp_lat = 0;
  int          rsp_cnt = 0;
  bit          rsp_pend = 0;
  logic [31:0] rsp_addr = '0;
  bit          stray = 0;
  logic [31:0] stray_data = '0;

  function automatic logic [31:0] mem_read(logic [31:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (mem_rd_en) begin
      rsp_pend = 1;
      rsp_cnt  = rsp_lat;
      rsp_addr = mem_rd_addr;
    end
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_read(rsp_addr);
        rsp_pend      = 0;
      end else begin
        rsp_cnt = rsp_cnt - 1;
      end
    end else if (stray) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = stray_data;
      stray         = 0;
    end
  end

  // behavioural reference, advanced at each rising edge
  int          m_ph = 0;
  logic [31:0] m_va = '0;
  logic [31:0] d;
  bit          m_started = 0;
  logic        e_rd = 0, e_done = 0, e_fault = 0, e_lvl = 0, e_busy = 0;
  logic [31:0] e_addr = '0, e_pa = '0;
  logic [11:0] e_fl = '0;

  always @(posedge clk) begin
    m_started = 1;
    if (rst) begin
      m_ph = 0; e_rd = 0; e_addr = 0; e_done = 0; e_fault = 0;
      e_lvl = 0; e_pa = 0; e_fl = 0;
    end else begin
      e_rd = 0; e_done = 0;
      if (m_ph == 0) begin
        if (req_valid) begin
          m_va   = req_vaddr;
          e_rd   = 1;
          e_addr = (ttb & 32'hFFFF_C000) + ((req_vaddr >> 20) << 2);
          m_ph   = 1;
        end
      end else if (mem_rsp_valid) begin
        d = mem_rsp_data;
        if (m_ph == 1 && d[1:0] == 2'b10) begin
          e_done = 1; e_fault = 0; e_lvl = 0;
          e_pa = (d & 32'hFFF0_0000) | (m_va & 32'h000F_FFFF);
          e_fl = d[11:0]; m_ph = 0;
        end else if (m_ph == 1 && d[1:0] == 2'b01) begin
          e_rd   = 1;
          e_addr = (d & 32'hFFFF_FC00) + (((m_va >> 12) & 32'hFF) << 2);
          m_ph   = 2;
        end else if (m_ph == 2 && d[1]) begin
          e_done = 1; e_fault = 0; e_lvl = 1;
          e_pa = (d & 32'hFFFF_F000) | (m_va & 32'h0000_0FFF);
          e_fl = d[11:0]; m_ph = 0;
        end else begin
          e_done = 1; e_fault = 1; e_lvl = (m_ph == 2);
          e_pa = 0; e_fl = 0; m_ph = 0;
        end
      end
    end
    e_busy = (m_ph != 0);
  end

  always @(negedge clk) begin
    if (m_started) begin
      n_tests++;
      if ({busy, done, mem_rd_en, fault, level} !== {e_busy, e_done, e_rd, e_fault, e_lvl} ||
          paddr !== e_pa || flags !== e_fl || mem_rd_addr !== e_addr) begin
        n_fail++;
        $display("FAIL %s cycle compare: act busy=%b done=%b rd=%b flt=%b lvl=%b pa=%h fl=%h ra=%h exp busy=%b done=%b rd=%b flt=%b lvl=%b pa=%h fl=%h ra=%h",
                 cur_tag, busy, done, mem_rd_en, fault, level, paddr, flags, mem_rd_addr,
                 e_busy, e_done, e_rd, e_fault, e_lvl, e_pa, e_fl, e_addr);
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic walk(string tag, logic [31:0] va, logic [31:0] base, int lat, bit intrude,
                      logic exp_fault, logic exp_lvl, logic [31:0] exp_pa, logic [11:0] exp_fl);
    @(negedge clk);
    cur_tag   = tag;
    rsp_lat   = lat;
    req_vaddr = va;
    ttb       = base;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " read strobe after accept"}, {31'b0, mem_rd_en}, 32'h1);
    check({tag, " R2 first read addr"}, mem_rd_addr,
          (base & 32'hFFFF_C000) | ((va >> 20) << 2));
    if (intrude) begin
      req_vaddr = 32'hFFF0_0000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    check({tag, " fault"}, {31'b0, fault}, {31'b0, exp_fault});
    check({tag, " level"}, {31'b0, level}, {31'b0, exp_lvl});
    check({tag, " paddr"}, paddr, exp_pa);
    check({tag, " flags"}, {20'b0, flags}, {20'b0, exp_fl});
    check({tag, " busy low at done"}, {31'b0, busy}, 32'h0);
    @(negedge clk);
    check({tag, " R9 done pulse"}, {31'b0, done}, 32'h0);
    check({tag, " R9 result held"}, paddr, exp_pa);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act hung exp finished");
    finish_run();
  end

  initial begin
    // tables: first level at 0x0004_0000, second level at 0x0009_0400
    mem_img[32'h0004_048C] = 32'h8760_0C02;  // section
    mem_img[32'h0004_0014] = 32'h0009_0401;  // table pointer
    mem_img[32'h0009_059C] = 32'hABCD_EFF2;  // valid page
    mem_img[32'h0009_0448] = 32'h5555_5FFD;  // invalid page
    mem_img[32'h0004_0C00] = 32'h1111_1113;  // reserved kind

    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check("R1 busy in reset", {31'b0, busy}, 32'h0);
    check("R1 paddr in reset", paddr, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", {31'b0, done}, 32'h0);
    check("R1 read strobe after reset", {31'b0, mem_rd_en}, 32'h0);

    walk("R3 section lat0", 32'h1234_5678, 32'h0004_0000, 0, 0, 0, 0, 32'h8764_5678, 12'hC02);
    walk("R3 section lat5 R10", 32'h1234_5678, 32'h0004_1234, 5, 0, 0, 0, 32'h8764_5678, 12'hC02);
    walk("R4 R5 page lat0", 32'h0056_7ABC, 32'h0004_0000, 0, 0, 0, 1, 32'hABCD_EABC, 12'hFF2);
    walk("R5 page lat3 R8 busy req", 32'h0056_7ABC, 32'h0004_0000, 3, 1, 0, 1, 32'hABCD_EABC, 12'hFF2);
    walk("R6 kind00", 32'h2000_0000, 32'h0004_0000, 2, 0, 1, 0, 32'h0, 12'h0);
    walk("R6 kind11", 32'h3000_0000, 32'h0004_0000, 0, 0, 1, 0, 32'h0, 12'h0);
    walk("R7 invalid page", 32'h0051_2345, 32'h0004_0000, 1, 0, 1, 1, 32'h0, 12'h0);
    walk("R3 section after fault", 32'h1230_0001, 32'h0004_0000, 4, 0, 0, 0, 32'h8760_0001, 12'hC02);

    // a response strobe while idle must leave everything unchanged
    @(negedge clk);
    cur_tag    = "R8 idle rsp";
    stray_data = 32'h0009_0401;
    stray      = 1;
    repeat (3) @(negedge clk);
    check("R8 idle rsp busy", {31'b0, busy}, 32'h0);
    check("R8 idle rsp paddr", paddr, 32'h8760_0001);
    check("R8 idle rsp no read", {31'b0, mem_rd_en}, 32'h0);

    walk("R4 R5 page after stray", 32'h0056_7ABC, 32'h0004_0000, 2, 0, 0, 1, 32'hABCD_EABC, 12'hFF2);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule